// File: doc/BRIEF.md
# Registered Fan-Out Buffer with Delayed Parity Check

This block registers a command/address word on each rising clock edge and drives every captured bit onto two identical output copies, so one source can feed twice the load. A few sideband control bits are registered alongside the word and take no part in the parity check.

An even-parity bit for each word arrives on a separate input after the word itself. The block folds that bit into the parity of the word and presents the result as a partial-parity output. When the result is one, it pulls an active-low error flag low and holds it there for a fixed number of cycles. A configuration pin picks the result latency. In solo mode the parity bit is sampled one cycle after the word and the result appears two cycles after the word. In cascade mode the parity bit is the partial-parity output of an upstream copy of this block; it is sampled two cycles after the word and the result appears three cycles after it.

Two active-low select inputs freeze every output when both are high. An active-low reset clears the block at once and takes priority over the selects. Its release is synchronised to the clock.

Top module: `regbuf_parity`

## Requirements
- R1: Unless the outputs are frozen, the word on `data_in` at a rising edge appears on both `q_a` and `q_b` after that edge. The two copies are always equal.
- R2: `side_in` is registered to `side_q` under the same freeze rule as the data word and has no influence on `ppo` or `perr_n`.
- R3: While `rst_n` is low, `q_a`, `q_b`, `side_q` and `ppo` are 0 and `perr_n` is 1, whatever the other inputs do.
- R4: At a rising edge where `cs0_n` and `cs1_n` are both 1, `q_a`, `q_b`, `side_q`, `ppo` and `perr_n` keep their values. The error hold count is also frozen.
- R5: At a rising edge where either `cs0_n` or `cs1_n` is 0, all outputs update normally.
- R6: With `cfg_back`=0, the word captured at edge k is paired with `par_in` sampled at edge k+1. The result drives `ppo` and `perr_n` after edge k+1.
- R7: With `cfg_back`=1, the word captured at edge k is paired with `par_in` sampled at edge k+2. The result drives `ppo` and `perr_n` after edge k+2.
- R8: `ppo` is the XOR of all `DATA_W` bits of the paired word and the paired `par_in`. A result of 1 is a parity error.
- R9: A parity error drives `perr_n` to 0 for `HOLD_CYCLES` (default 2) consecutive cycles. It then returns to 1 unless another error arrives.
- R10: A new error while `perr_n` is already 0 restarts the full `HOLD_CYCLES` hold from that edge.
- R11: After `rst_n` rises, the block stays in reset for `SYNC_STAGES` (default 2) rising edges. The first word is captured at the next edge.
- R12: Lowering `rst_n` between clock edges clears all outputs, including a `perr_n` that is being held low, without waiting for an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| cfg_back | input | 1 | 0 = solo latency, 1 = cascade latency |
| cs0_n | input | 1 | Select A, active low |
| cs1_n | input | 1 | Select B, active low |
| data_in | input | DATA_W | Word to register and check |
| side_in | input | SIDE_W | Sideband controls, excluded from parity |
| par_in | input | 1 | Delayed parity bit for an earlier word |
| q_a | output | DATA_W | First registered copy |
| q_b | output | DATA_W | Second registered copy |
| side_q | output | SIDE_W | Registered sideband |
| ppo | output | 1 | Partial-parity result |
| perr_n | output | 1 | Parity error flag, active low, stretched |

## Verification
The bench builds the block with its defaults: a 14-bit word, 3 sideband bits, a two-cycle error hold and a two-stage reset synchroniser. The short hold makes back-to-back errors and hold restarts easy to reach, both in directed sequences and in random traffic that injects roughly one bad parity bit in eight. The two-stage synchroniser keeps the release window short enough to pin down the exact first capture edge. Both latency settings are run over the same random stream, with freeze periods mixed in, so a misaligned parity pairing shows up as a wrong `ppo` value.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

    typedef enum logic {
        LAT_SOLO    = 1'b0,
        LAT_CASCADE = 1'b1
    } lat_mode_e;

    function automatic logic outputs_frozen(input logic sel_a_n, input logic sel_b_n);
        return sel_a_n & sel_b_n;
    endfunction

endpackage

// File: rtl/regbuf_rst_sync.sv
module regbuf_rst_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [NS-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[NS-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign srst_n = chain_q[NS-1];
endmodule

// File: rtl/regbuf_fanout.sv
module regbuf_fanout #(
    parameter int DATA_W = 14,
    parameter int SIDE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic [DATA_W-1:0] data_in,
    input  logic [SIDE_W-1:0] side_in,
    output logic [DATA_W-1:0] q_a,
    output logic [DATA_W-1:0] q_b,
    output logic [SIDE_W-1:0] side_q
);
    typedef struct packed {
        logic [DATA_W-1:0] copy_a;
        logic [DATA_W-1:0] copy_b;
        logic [SIDE_W-1:0] side;
    } fan_st_t;

    fan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!freeze) begin
            st_d.copy_a = data_in;
            st_d.copy_b = data_in;
            st_d.side   = side_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_a    = st_q.copy_a;
    assign q_b    = st_q.copy_b;
    assign side_q = st_q.side;

    AST_CAPTURE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !freeze) |=> (q_a == $past(data_in) && q_b == $past(data_in))); // R1
    AST_FREEZE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && freeze) |=> ($stable(q_a) && $stable(q_b) && $stable(side_q))); // R4
endmodule

// File: rtl/regbuf_parity_chk.sv
module regbuf_parity_chk
    import regbuf_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int HOLD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  lat_mode_e         mode,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_in,
    output logic              ppo,
    output logic              perr_n
);
    localparam int PIPE_D = 2;
    localparam int HOLD_V = (HOLD_CYCLES < 1) ? 1 : HOLD_CYCLES;
    localparam int CNT_W  = (HOLD_V > 1) ? $clog2(HOLD_V) : 1;

    typedef struct packed {
        logic [PIPE_D-1:0] wpar;
        logic              ppo;
        logic              err_n;
        logic [CNT_W-1:0]  left;
    } chk_st_t;

    chk_st_t st_d, st_q;
    logic    paired_par;
    logic    result;

    always_comb begin
        paired_par = (mode == LAT_CASCADE) ? st_q.wpar[PIPE_D-1] : st_q.wpar[PIPE_D-2];
        result     = paired_par ^ par_in;

        st_d      = st_q;
        st_d.wpar = {st_q.wpar[PIPE_D-2:0], ^data_in};
        if (!freeze) begin
            st_d.ppo = result;
            if (result) begin
                st_d.err_n = 1'b0;
                st_d.left  = CNT_W'(HOLD_V - 1);
            end else if (!st_q.err_n && st_q.left != '0) begin
                st_d.left = st_q.left - 1'b1;
            end else begin
                st_d.err_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.err_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ppo    = st_q.ppo;
    assign perr_n = st_q.err_n;

    AST_FREEZE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && freeze) |=> ($stable(ppo) && $stable(perr_n))); // R4
    AST_ERR_FROM_PPO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_n) |-> ppo); // R8
    AST_ERR_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_n) |=> !perr_n); // R9
endmodule

// File: rtl/regbuf_parity.sv
module regbuf_parity
    import regbuf_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int SIDE_W      = 3,
    parameter int HOLD_CYCLES = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_back,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic [SIDE_W-1:0] side_in,
    input  logic              par_in,
    output logic [DATA_W-1:0] q_a,
    output logic [DATA_W-1:0] q_b,
    output logic [SIDE_W-1:0] side_q,
    output logic              ppo,
    output logic              perr_n
);
    logic      core_rst_n;
    logic      freeze;
    lat_mode_e mode;

    assign freeze = outputs_frozen(cs0_n, cs1_n);
    assign mode   = cfg_back ? LAT_CASCADE : LAT_SOLO;

    regbuf_rst_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_rst_sync (
        .clk    (clk),
        .arst_n (rst_n),
        .srst_n (core_rst_n)
    );

    regbuf_fanout #(
        .DATA_W(DATA_W),
        .SIDE_W(SIDE_W)
    ) i_fanout (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .freeze  (freeze),
        .data_in (data_in),
        .side_in (side_in),
        .q_a     (q_a),
        .q_b     (q_b),
        .side_q  (side_q)
    );

    regbuf_parity_chk #(
        .DATA_W      (DATA_W),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) i_parity (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .freeze  (freeze),
        .mode    (mode),
        .data_in (data_in),
        .par_in  (par_in),
        .ppo     (ppo),
        .perr_n  (perr_n)
    );
endmodule

// File: tb/test_regbuf_parity.sv
`timescale 1ns/1ps
module test_regbuf_parity;
    localparam int DW = 14;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_back = 1'b0;
    logic          cs0_n = 1'b0;
    logic          cs1_n = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [SW-1:0] side_in = '0;
    logic          par_in = 1'b0;
    logic [DW-1:0] q_a, q_b;
    logic [SW-1:0] side_q;
    logic          ppo, perr_n;

    int n_checks = 0;
    int n_fail   = 0;

    // expected state derived from the requirements
    logic [DW-1:0] e_q;
    logic [SW-1:0] e_s;
    logic          e_ppo, e_errn;
    int            e_left;
    logic          h1, h2;
    string         tag;

    always #2.5 clk = ~clk;

    regbuf_parity i_regbuf_parity (
        .clk(clk), .rst_n(rst_n), .cfg_back(cfg_back), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .data_in(data_in), .side_in(side_in), .par_in(par_in),
        .q_a(q_a), .q_b(q_b), .side_q(side_q), .ppo(ppo), .perr_n(perr_n)
    );

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        e_q = '0; e_s = '0; e_ppo = 1'b0; e_errn = 1'b1; e_left = 0; h1 = 1'b0; h2 = 1'b0;
    endtask

    function automatic logic pair_bit(input logic cfg);
        return cfg ? h2 : h1;
    endfunction

    // one cycle: inputs set at negedge, edge, compare at next negedge
    task automatic step(input logic [DW-1:0] d, input logic [SW-1:0] s, input logic p,
                        input logic a_n, input logic b_n);
        logic calc;
        data_in = d; side_in = s; par_in = p; cs0_n = a_n; cs1_n = b_n;
        @(posedge clk);
        calc = pair_bit(cfg_back) ^ p;
        if (!(a_n && b_n)) begin
            e_q = d; e_s = s; e_ppo = calc;
            if (calc) begin
                e_errn = 1'b0; e_left = 1;
            end else if (!e_errn && e_left > 0) begin
                e_left--;
            end else begin
                e_errn = 1'b1;
            end
        end
        h2 = h1; h1 = ^d;
        @(negedge clk);
        chk("R1 q_a", 32'(q_a), 32'(e_q));
        chk("R1 q_b", 32'(q_b), 32'(e_q));
        chk("R2 side_q", 32'(side_q), 32'(e_s));
        chk({tag, " ppo"}, 32'(ppo), 32'(e_ppo));
        chk({tag, " perr_n"}, 32'(perr_n), 32'(e_errn));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            data_in = DW'($urandom); side_in = SW'($urandom); par_in = 1'($urandom);
            cs0_n = 1'($urandom); cs1_n = 1'($urandom);
            @(negedge clk);
            chk("R3 q_a in reset", 32'(q_a), 0);
            chk("R3 ppo in reset", 32'(ppo), 0);
            chk("R3 perr_n in reset", 32'(perr_n), 1);
        end
        data_in = '0; side_in = '0; par_in = 1'b0; cs0_n = 1'b0; cs1_n = 1'b0;
        rst_n = 1'b1;
        model_clear();
        tag = "R11";
        for (int i = 0; i < 3; i++) step('0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0419));
        model_clear();
        tag = "R3";
        @(negedge clk);
        chk("R3 q_b at start", 32'(q_b), 0);
        chk("R3 perr_n at start", 32'(perr_n), 1);
        do_reset();

        // R11: release with live data; two edges still in reset, third captures
        rst_n = 1'b0;
        @(negedge clk);
        data_in = 14'h2A5C; rst_n = 1'b1;
        @(negedge clk);
        chk("R11 q_a after edge 1", 32'(q_a), 0);
        @(negedge clk);
        chk("R11 q_a after edge 2", 32'(q_a), 0);
        @(negedge clk);
        chk("R11 q_a after edge 3", 32'(q_a), 32'h2A5C);
        do_reset();

        // R6: solo latency, word with odd weight, correct parity then wrong parity
        cfg_back = 1'b0; tag = "R6";
        step(14'h0001, 3'h5, 1'b0, 1'b0, 1'b0);
        step(14'h0003, 3'h2, 1'b1, 1'b0, 1'b0);  // pairs with 0x0001: ok
        chk("R6 ppo ok", 32'(ppo), 0);
        step(14'h0000, 3'h7, 1'b1, 1'b0, 1'b0);  // pairs with 0x0003 (even) + 1: error
        chk("R6 perr_n low", 32'(perr_n), 0);
        tag = "R9";
        step('0, '0, 1'b0, 1'b0, 1'b0);
        chk("R9 held second cycle", 32'(perr_n), 0);
        step('0, '0, 1'b0, 1'b0, 1'b0);
        chk("R9 released", 32'(perr_n), 1);

        // R10: second error one cycle into the hold restarts it
        tag = "R10";
        step('0, '0, 1'b1, 1'b0, 1'b0);          // error
        step('0, '0, 1'b1, 1'b0, 1'b0);          // error again, restart
        step('0, '0, 1'b0, 1'b0, 1'b0);
        chk("R10 still low after restart", 32'(perr_n), 0);
        step('0, '0, 1'b0, 1'b0, 1'b0);
        chk("R10 released", 32'(perr_n), 1);

        // R7: cascade latency
        cfg_back = 1'b1; tag = "R7";
        step(14'h0007, '0, 1'b0, 1'b0, 1'b0);
        step(14'h0000, '0, 1'b0, 1'b0, 1'b0);
        step(14'h0000, '0, 1'b1, 1'b0, 1'b0);    // pairs with 0x0007: ok
        chk("R7 ppo ok", 32'(ppo), 0);
        step(14'h0000, '0, 1'b1, 1'b0, 1'b0);    // pairs with 0: error
        chk("R7 perr_n low", 32'(perr_n), 0);

        // R4: freeze during a held error, R5: one select low resumes
        tag = "R4";
        for (int i = 0; i < 4; i++) step(DW'($urandom), SW'($urandom), 1'($urandom), 1'b1, 1'b1);
        chk("R4 perr_n frozen low", 32'(perr_n), 0);
        tag = "R5";
        step(14'h1234, 3'h1, 1'b0, 1'b1, 1'b0);
        step(14'h0F0F, 3'h6, 1'b0, 1'b0, 1'b1);
        chk("R5 q_a updated", 32'(q_a), 32'h0F0F);

        // R12: asynchronous reset during a held error
        tag = "R12";
        cfg_back = 1'b0;
        step(14'h0001, '0, 1'b0, 1'b0, 1'b0);
        step(14'h0000, '0, 1'b0, 1'b0, 1'b0);    // pairs with odd word, par 0: error
        chk("R12 perr_n low before reset", 32'(perr_n), 0);
        #1 rst_n = 1'b0;
        #0.5;
        chk("R12 perr_n cleared", 32'(perr_n), 1);
        chk("R12 q_a cleared", 32'(q_a), 0);
        @(negedge clk);
        do_reset();

        // R8 / R2: random traffic in both modes, occasional bad parity and freeze
        tag = "R8";
        for (int i = 0; i < 3000; i++) begin
            logic [DW-1:0] d;
            logic          good;
            logic          fr;
            if (i == 1500) cfg_back = 1'b1;
            d    = DW'($urandom);
            good = pair_bit(cfg_back);
            fr   = ($urandom % 6) == 0;
            step(d, SW'($urandom), good ^ (($urandom % 8) == 0),
                 fr ? 1'b1 : 1'($urandom), fr ? 1'b1 : 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule